// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block gathers 64 interrupt inputs into two request lines, a normal request `irq` and a fast request `fiq`. Each source has a one-byte control register that holds three things. One is an enable. Another is a trigger kind: high level, rising edge, falling edge or either edge. The third is a 3-bit route code. Edge events are caught in sticky status bits, which software acknowledges by writing ones to them. Level sources report the live synchronized input. A priority resolver picks one pending, enabled, irq-routed source and shows its number in a readable winner register.

The resolver works in one of two ways. In fixed order the lowest-numbered source wins. In rotating order the search starts just above the most recently serviced source and wraps from 63 to 0. When nothing is pending, the winner register reads 63. Software tells this idle value apart from a real request by source 63 by reading status bit 31 of the upper status word. Route codes 2 to 7 are stored and read back, but they drive neither request line.

Top module: `rotprio_intc`

## Requirements
- R1: After reset all control bytes, both status words and both priority control registers read 0, `irq` and `fiq` are low, and the winner register at 0x00 reads 63.
- R2: Source s has its control byte at byte address 0x40+s, in byte lane s mod 4 of word 0x40+4*(s/4). Bit 3 is enable and bits 2:0 are the route (0 irq, 1 fiq, 2..7 stored only). A write changes only the bytes whose byte enable is set, and all 8 bits read back.
- R3: With trigger bits 6:5 = 00 (level), the status bit equals the synchronized input ANDed with enable, two clocks after the input changes. Writes to that status bit are ignored.
- R4: With trigger 01 (rising), a 0-to-1 input change sets the status bit even while the source is disabled. The bit stays set until a 1 is written to it, and it requests an interrupt only while enabled.
- R5: Trigger 10 latches on a 1-to-0 input change and trigger 11 latches on either change. A steady input latches nothing.
- R6: Status for sources 0..31 is at 0x80 and for sources 32..63 at 0x84, at bit s mod 32. Writing 1 to an edge bit clears it, and a new edge in the same clock wins over the clear.
- R7: `irq` is high exactly while some enabled source routed to code 0 is pending, and `fiq` likewise for code 1. Sources with codes 2..7 raise neither line.
- R8: The winner register at 0x00 gives the chosen irq source in bits 5:0, and 63 when no irq-routed source is pending.
- R9: With rotation off (bit 6 of 0x20 clear), the lowest-numbered pending irq source wins.
- R10: A source is serviced when it is the winner and either its edge bit is acknowledged or its enable is cleared. The next search then starts at that number plus one, modulo 64. With rotation on, the first pending source at or after the start point wins.
- R11: The irq priority control at 0x20 and the fiq priority control at 0x24 store bits 6:0 and read them back. Their other bits read 0. Bit 6 of 0x20 turns on rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one clock per write |
| reg_addr | input | 8 | Byte address of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables for writes |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_in | input | 64 | Raw asynchronous interrupt inputs |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
A wrong value in an edge latch shows up on the first read of the status word. It also holds `irq` high, or keeps it low, from the clock after the bad edge, and the number at 0x00 does not change after an acknowledge. A bad rotation start point is invisible in fixed order. In rotating order it gives a different winner on the read that follows an acknowledge, so the bench leaves two sources pending on either side of the start point. Synchronizer depth errors move level status by one clock, so the checks wait a known number of clocks after each input change.

// File: rtl/rpic_pkg.sv
package rpic_pkg;
    // Register addresses that software decodes
    localparam logic [7:0] A_WINNER  = 8'h00;
    localparam logic [7:0] A_IRQ_PRI = 8'h20;
    localparam logic [7:0] A_FIQ_PRI = 8'h24;
    localparam logic [1:0] A_CTRL_TOP = 2'b01;   // reg_addr[7:6] of the control bytes
    localparam logic [4:0] A_STAT_TOP = 5'b10000; // reg_addr[7:3] of the status words

    // Control byte fields
    localparam int EN_POS  = 3;
    localparam int TRIG_LO = 5;
    localparam int PRI_W   = 7;
    localparam int ROT_POS = 6;
    localparam logic [2:0] ROUTE_IRQ = 3'd0;
    localparam logic [2:0] ROUTE_FIQ = 3'd1;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_RISE  = 2'b01,
        TRIG_FALL  = 2'b10,
        TRIG_ANY   = 2'b11
    } trig_e;
endpackage

// File: rtl/rpic_sync.sv
module rpic_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rpic_edge.sv
module rpic_edge #(
    parameter int WIDTH = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WIDTH-1:0]      level_i,
    input  logic [WIDTH-1:0][1:0] trig_i,
    input  logic [WIDTH-1:0]      clr_i,
    output logic [WIDTH-1:0]      latched_o
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] hold;
    } edge_st_t;

    edge_st_t         st_d, st_q;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] edge_mode;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            hit[i] = (trig_i[i][0] &  level_i[i] & ~st_q.prev[i])
                   | (trig_i[i][1] & ~level_i[i] &  st_q.prev[i]);
            edge_mode[i] = |trig_i[i];
        end
        st_d.prev = level_i;
        // a new edge in the same clock wins over the acknowledge
        st_d.hold = ((st_q.hold & ~clr_i) | hit) & edge_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latched_o = st_q.hold;

    // R6: an acknowledged bit without a fresh edge is gone one clock later
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.hold & $past(clr_i & ~hit)) == '0));

    // R4: a latch bit only rises because an edge was seen
    assert_latch_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.hold & ~$past(st_q.hold) & ~$past(hit)) == '0));
endmodule

// File: rtl/rpic_pick.sv
module rpic_pick #(
    parameter int W   = 64,
    parameter int IDW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   req_i,
    input  logic           rotate_i,
    input  logic [IDW-1:0] start_i,
    output logic           valid_o,
    output logic [IDW-1:0] id_o
);
    localparam logic [IDW-1:0] IDLE_ID = IDW'(W - 1);

    logic [IDW-1:0] base;
    logic [IDW-1:0] idx;
    logic           found;
    logic [W-1:0]   below_mask;

    always_comb begin
        base  = rotate_i ? start_i : '0;
        found = 1'b0;
        id_o  = IDLE_ID;
        idx   = '0;
        for (int k = 0; k < W; k++) begin
            idx = base + IDW'(k);
            if (!found && req_i[idx]) begin
                found = 1'b1;
                id_o  = idx;
            end
        end
        valid_o = found;
    end

    assign below_mask = ({{(W-1){1'b0}}, 1'b1} << id_o) - 1'b1;

    // R8: a chosen source is really requesting
    assert_pick_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> req_i[id_o]);

    // R8: with nothing requesting the idle code is shown
    assert_idle_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (id_o == IDLE_ID));

    // R9: fixed order never skips a lower requester
    assert_fixed_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !rotate_i) |-> ((req_i & below_mask) == '0));
endmodule

// File: rtl/rotprio_intc.sv
module rotprio_intc
    import rpic_pkg::*;
#(
    parameter int NUM_SRC     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic [3:0]         reg_be,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq,
    output logic               fiq
);
    localparam int              ID_W    = $clog2(NUM_SRC);
    localparam logic [ID_W-1:0] IDLE_ID = ID_W'(NUM_SRC - 1);

    typedef struct packed {
        logic [NUM_SRC-1:0][7:0] ctrl;
        logic [PRI_W-1:0]        irq_pri;
        logic [PRI_W-1:0]        fiq_pri;
        logic [ID_W-1:0]         rot_start;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_SRC-1:0]      src_sync;
    logic [NUM_SRC-1:0]      edge_hold;
    logic [NUM_SRC-1:0]      stat_clr;
    logic [NUM_SRC-1:0]      status;
    logic [NUM_SRC-1:0]      en;
    logic [NUM_SRC-1:0]      irq_req;
    logic [NUM_SRC-1:0]      fiq_req;
    logic [NUM_SRC-1:0][1:0] trig;
    logic                    pick_valid;
    logic [ID_W-1:0]         pick_id;
    logic                    aligned, hit_ctrl, hit_stat;

    rpic_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_in),
        .sync_o  (src_sync)
    );

    rpic_edge #(.WIDTH(NUM_SRC)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (src_sync),
        .trig_i    (trig),
        .clr_i     (stat_clr),
        .latched_o (edge_hold)
    );

    rpic_pick #(.W(NUM_SRC), .IDW(ID_W)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (irq_req),
        .rotate_i (r_q.irq_pri[ROT_POS]),
        .start_i  (r_q.rot_start),
        .valid_o  (pick_valid),
        .id_o     (pick_id)
    );

    // Address decode
    always_comb begin
        aligned  = (reg_addr[1:0] == 2'b00);
        hit_ctrl = aligned && (reg_addr[7:6] == A_CTRL_TOP);
        hit_stat = aligned && (reg_addr[7:3] == A_STAT_TOP);
    end

    // Per-source status and request
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            en[s]      = r_q.ctrl[s][EN_POS];
            trig[s]    = r_q.ctrl[s][TRIG_LO +: 2];
            status[s]  = (trig_e'(trig[s]) == TRIG_LEVEL) ? (src_sync[s] & en[s]) : edge_hold[s];
            irq_req[s] = status[s] & en[s] & (r_q.ctrl[s][2:0] == ROUTE_IRQ);
            fiq_req[s] = status[s] & en[s] & (r_q.ctrl[s][2:0] == ROUTE_FIQ);
        end
    end

    // Next state
    always_comb begin
        r_d      = r_q;
        stat_clr = '0;
        if (reg_wr) begin
            if (reg_addr == A_IRQ_PRI && reg_be[0]) r_d.irq_pri = reg_wdata[PRI_W-1:0];
            if (reg_addr == A_FIQ_PRI && reg_be[0]) r_d.fiq_pri = reg_wdata[PRI_W-1:0];
            for (int s = 0; s < NUM_SRC; s++) begin
                if (hit_ctrl && reg_addr[5:2] == 4'(s / 4) && reg_be[s % 4])
                    r_d.ctrl[s] = reg_wdata[(s % 4) * 8 +: 8];
                if (hit_stat && reg_addr[2] == 1'(s / 32) && reg_be[(s % 32) / 8]
                    && reg_wdata[s % 32])
                    stat_clr[s] = 1'b1;
            end
        end
        // service of the current winner moves the rotation start
        if (pick_valid && ((stat_clr[pick_id] && edge_hold[pick_id])
                           || !r_d.ctrl[pick_id][EN_POS]))
            r_d.rot_start = pick_id + ID_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Read path
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            if (reg_addr == A_WINNER)       reg_rdata = 32'(pick_id);
            else if (reg_addr == A_IRQ_PRI) reg_rdata = 32'(r_q.irq_pri);
            else if (reg_addr == A_FIQ_PRI) reg_rdata = 32'(r_q.fiq_pri);
            else if (hit_ctrl) begin
                for (int l = 0; l < 4; l++)
                    reg_rdata[l * 8 +: 8] = r_q.ctrl[{reg_addr[5:2], 2'(l)}];
            end
            else if (hit_stat) reg_rdata = reg_addr[2] ? status[63:32] : status[31:0];
        end
    end

    assign irq = |irq_req;
    assign fiq = |fiq_req;

    // R1: leaving reset, no request is raised
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && !fiq));

    // R7: irq implies the reported winner is enabled and irq-routed
    assert_winner_routed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (r_q.ctrl[pick_id][EN_POS] && r_q.ctrl[pick_id][2:0] == ROUTE_IRQ));

    // R8: with irq low the winner register holds the idle code
    assert_idle_when_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (pick_id == IDLE_ID));

    // R10: the start point only ever moves to one past the previous winner
    assert_rot_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.rot_start != $past(r_q.rot_start)) |-> (r_q.rot_start == $past(pick_id) + ID_W'(1)));
endmodule

// File: tb/rotprio_intc_test.sv
`timescale 1ns/1ps
module rotprio_intc_test;
    localparam time TCLK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_rdata;
    logic [63:0] src_in = '0;
    logic        irq, fiq;

    rotprio_intc uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
        .src_in(src_in), .irq(irq), .fiq(fiq)
    );

    always #(TCLK / 2) clk = ~clk;

    typedef struct {
        int          kind;   // 0 read data, 1 irq, 2 fiq
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    item_t       cur;
    logic [31:0] act;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    // Monitor: one expected item per clock, compared away from the edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            cur = sb.pop_front();
            case (cur.kind)
                0:       act = reg_rdata;
                1:       act = {31'b0, irq};
                default: act = {31'b0, fiq};
            endcase
            n_chk++;
            if (act !== cur.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", cur.tag, act, cur.exp);
            end
        end
    end

    // Driver tasks: each starts and ends 1 ns after a rising edge
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        idle(1);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.kind = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        idle(1);
    endtask

    task automatic exp_line(input int kind, input logic v, input string tag);
        item_t it;
        it.kind = kind; it.exp = {31'b0, v}; it.tag = tag;
        sb.push_back(it);
        idle(1);
    endtask

    task automatic pulse(input int s);
        src_in[s] = 1'b1;
        idle(1);
        src_in[s] = 1'b0;
        idle(5);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        exp_rd(8'h00, 32'd63, "R1 winner idle");
        exp_rd(8'h20, 32'h0, "R1 irq pri");
        exp_rd(8'h24, 32'h0, "R1 fiq pri");
        exp_rd(8'h40, 32'h0, "R1 ctrl");
        exp_rd(8'h80, 32'h0, "R1 stat lo");
        exp_rd(8'h84, 32'h0, "R1 stat hi");
        exp_line(1, 1'b0, "R1 irq");
        exp_line(2, 1'b0, "R1 fiq");

        // R2 byte-lane writes: src4 = 0x0F (aux route), src6 = 0x09
        wr(8'h44, 32'h0A09080F, 4'b0101);
        exp_rd(8'h44, 32'h0009000F, "R2 byte enables");

        // R7 aux route raises nothing
        src_in[4] = 1'b1; idle(4);
        exp_rd(8'h80, 32'h00000010, "R7 aux status");
        exp_line(1, 1'b0, "R7 aux no irq");
        exp_line(2, 1'b0, "R7 aux no fiq");
        src_in[4] = 1'b0;
        wr(8'h44, 32'h0, 4'hF);
        idle(4);

        // R3 level source 5
        wr(8'h44, 32'h00000800, 4'b0010);
        src_in[5] = 1'b1; idle(4);
        exp_rd(8'h80, 32'h00000020, "R3 level status");
        exp_line(1, 1'b1, "R7 level irq");
        exp_rd(8'h00, 32'd5, "R8 winner 5");
        wr(8'h80, 32'hFFFFFFFF, 4'hF);
        exp_rd(8'h80, 32'h00000020, "R3 write ignored");
        wr(8'h44, 32'h0, 4'b0010);
        exp_rd(8'h80, 32'h0, "R3 disabled gates status");
        wr(8'h44, 32'h00000800, 4'b0010);
        src_in[5] = 1'b0; idle(4);
        exp_rd(8'h80, 32'h0, "R3 follows input");
        exp_line(1, 1'b0, "R7 irq drops");
        exp_rd(8'h00, 32'd63, "R8 idle again");
        wr(8'h44, 32'h0, 4'b0010);

        // R4 rising source 33, disabled first
        wr(8'h60, 32'h00002000, 4'b0010);
        pulse(33);
        exp_rd(8'h84, 32'h00000002, "R4 latched while disabled");
        exp_line(1, 1'b0, "R4 no irq when disabled");
        wr(8'h60, 32'h00002800, 4'b0010);
        exp_line(1, 1'b1, "R4 irq once enabled");
        exp_rd(8'h00, 32'd33, "R8 winner 33");
        wr(8'h84, 32'h00000002, 4'hF);
        exp_rd(8'h84, 32'h0, "R6 ack clears");
        exp_line(1, 1'b0, "R4 irq cleared");
        wr(8'h60, 32'h0, 4'b0010);

        // R5 falling source 63
        wr(8'h7C, 32'h48000000, 4'b1000);
        src_in[63] = 1'b1; idle(5);
        exp_rd(8'h84, 32'h0, "R5 rise ignored by falling");
        src_in[63] = 1'b0; idle(5);
        exp_rd(8'h84, 32'h80000000, "R5 falling latched");
        exp_rd(8'h00, 32'd63, "R8 real 63");
        exp_line(1, 1'b1, "R8 irq with 63");
        wr(8'h84, 32'h80000000, 4'b1000);
        exp_line(1, 1'b0, "R6 ack 63");
        wr(8'h7C, 32'h0, 4'b1000);

        // R5 either edge source 62
        wr(8'h7C, 32'h00680000, 4'b0100);
        src_in[62] = 1'b1; idle(5);
        exp_rd(8'h84, 32'h40000000, "R5 any edge rise");
        exp_rd(8'h00, 32'd62, "R8 winner 62");
        wr(8'h84, 32'h40000000, 4'hF);
        src_in[62] = 1'b0; idle(5);
        exp_rd(8'h84, 32'h40000000, "R5 any edge fall");
        wr(8'h84, 32'h40000000, 4'hF);
        exp_rd(8'h84, 32'h0, "R6 ack 62");
        wr(8'h7C, 32'h0, 4'b0100);

        // R7 fiq route source 10
        wr(8'h48, 32'h00090000, 4'b0100);
        src_in[10] = 1'b1; idle(4);
        exp_line(2, 1'b1, "R7 fiq high");
        exp_line(1, 1'b0, "R7 irq low for fiq source");
        exp_rd(8'h00, 32'd63, "R8 fiq not reported");
        src_in[10] = 1'b0; idle(4);
        exp_line(2, 1'b0, "R7 fiq low");
        wr(8'h48, 32'h0, 4'b0100);

        // R9 fixed order with rising sources 3, 7, 20
        wr(8'h40, 32'h28000000, 4'b1000);
        wr(8'h44, 32'h28000000, 4'b1000);
        wr(8'h54, 32'h00000028, 4'b0001);
        src_in[3] = 1'b1; src_in[7] = 1'b1; src_in[20] = 1'b1; idle(1);
        src_in[3] = 1'b0; src_in[7] = 1'b0; src_in[20] = 1'b0; idle(5);
        exp_rd(8'h00, 32'd3, "R9 lowest 3");
        wr(8'h80, 32'h00000008, 4'hF);
        exp_rd(8'h00, 32'd7, "R9 then 7");
        wr(8'h80, 32'h00000080, 4'hF);
        exp_rd(8'h00, 32'd20, "R9 then 20");
        wr(8'h80, 32'h00100000, 4'hF);
        exp_rd(8'h00, 32'd63, "R9 all served");

        // R11 priority control registers
        wr(8'h20, 32'hFFFFFFFF, 4'hF);
        exp_rd(8'h20, 32'h0000007F, "R11 irq pri bits");
        wr(8'h24, 32'h0000003F, 4'hF);
        exp_rd(8'h24, 32'h0000003F, "R11 fiq pri");
        wr(8'h20, 32'h00000040, 4'hF);

        // R10 rotation: start point is 21 after serving 20
        src_in[3] = 1'b1; src_in[7] = 1'b1; src_in[20] = 1'b1; idle(1);
        src_in[3] = 1'b0; src_in[7] = 1'b0; src_in[20] = 1'b0; idle(5);
        exp_rd(8'h00, 32'd3, "R10 wrap to 3");
        wr(8'h80, 32'h00000008, 4'hF);
        exp_rd(8'h00, 32'd7, "R10 next 7");
        pulse(3);
        wr(8'h80, 32'h00000080, 4'hF);
        exp_rd(8'h00, 32'd20, "R10 20 before 3");
        wr(8'h80, 32'h00100000, 4'hF);
        exp_rd(8'h00, 32'd3, "R10 wrap again");
        wr(8'h80, 32'h00000008, 4'hF);
        exp_line(1, 1'b0, "R10 drained");

        idle(2);
        done = 1'b1;
        summary();
    end
endmodule